// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block collects a vector of external interrupt request lines and decides which one a processor core should service next. Each line has an enable flag, a pending flag, an active flag and a 4-bit priority. A rising edge on a request line marks it pending, even when the line is disabled. Among the lines that are both pending and enabled, the most urgent one is offered to the core together with its exception number.

The core answers with an entry acknowledge when it starts a handler and with an exit pulse when the handler returns. The controller keeps a small stack of the running handlers, so that a more urgent request can interrupt a handler that is already running, and the earlier execution priority comes back when that handler exits. Software reaches the flags and priorities through a simple word-wide register bus. The bus has separate write-one-to-set and write-one-to-clear addresses, and reads are combinational.

Top module: `nested_irq_ctrl`

## Requirements
- R1: A write to set-enable word w (address 0x00+w) sets the enable bit of every line whose bit is 1 in the data; 0 bits have no effect. Line n sits in word n/32 at bit n%32. A read of this address returns the enable bits.
- R2: A write to clear-enable word w (address 0x20+w) clears the enable bits whose data bit is 1; 0 bits have no effect. A read returns the enable bits.
- R3: A write to set-pending word w (0x40+w) sets pending bits, and a write to clear-pending word w (0x60+w) clears them, in both cases only where the data bit is 1. A read of either address returns the pending bits.
- R4: A rising edge on a request line sets its pending bit at the next clock edge, whether or not the line is enabled. A pending line that is disabled is not offered; once it is enabled it is offered, subject to R6.
- R5: Among pending, enabled lines the one with the numerically lowest priority is offered, and on a tie the lowest line number wins. `irq_num` is that line number plus 16.
- R6: A candidate is offered (`irq_valid`=1) only when no handler is active, or when its priority value is strictly lower than that of the innermost active handler.
- R7: `core_ack` while `irq_valid` is high (and `core_exit` is low) clears the offered line's pending bit, sets its active bit and leaves its enable bit unchanged. The active bits read at address 0x80+w.
- R8: `core_exit` while a handler is active clears the active bit of the innermost handler and restores the previous execution priority. It takes precedence over a `core_ack` in the same cycle, which is then ignored.
- R9: If a request edge and a clear-pending write for the same line fall in one cycle, the line ends up pending.
- R10: While DEPTH (default 4) handlers are active, nothing is offered until one exits.
- R11: Priority word p (address 0xA0+p) holds lines 8p to 8p+7, with line n in bits 4*(n%8)+3 down to 4*(n%8). The word is writable and reads back.
- R12: After reset all enable, pending and active bits and all priorities are 0, and `irq_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address: bits 7:5 select the region, bits 4:0 the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_lines | input | NUM_IRQ | Interrupt request lines, rising-edge sensitive |
| core_ack | input | 1 | Core takes the offered interrupt |
| core_exit | input | 1 | Innermost handler returns |
| irq_valid | output | 1 | An interrupt is offered to the core |
| irq_num | output | 9 | Exception number of the offered interrupt |

## Verification
Every register update, whether from the bus, a request edge, an acknowledge or an exit, lands at the first rising clock edge after the stimulus. `irq_valid`, `irq_num` and `bus_rdata` are combinational from that state, so they are due just after that edge. The bench drives stimuli on the falling edge, lets one rising edge pass and then samples at the next falling edge, or one time step after it for a read, when the outputs have settled. The arbitration sweep removes one line per step and compares each offer against a minimum search computed in the bench.

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl #(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 4,
  parameter int DEPTH   = 4,
  parameter int EXC_OFS = 16,
  parameter int EXC_W   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic               core_ack,
  input  logic               core_exit,
  output logic               irq_valid,
  output logic [EXC_W-1:0]   irq_num
);
  localparam int NWORDS = NUM_IRQ / 32;
  localparam int PER_PW = 32 / PRIO_W;
  localparam int PWORDS = NUM_IRQ / PER_PW;
  localparam int LINE_W = $clog2(NUM_IRQ);
  localparam int DEP_W  = $clog2(DEPTH + 1);
  localparam logic [DEP_W-1:0] FULL = DEP_W'(DEPTH);
  localparam logic [NUM_IRQ-1:0] ONE = {{(NUM_IRQ-1){1'b0}}, 1'b1};

  logic [NUM_IRQ-1:0] en, pend, act, prev;
  logic [PRIO_W-1:0]  prio [NUM_IRQ];
  logic [LINE_W-1:0]  stk_line [DEPTH];
  logic [PRIO_W-1:0]  stk_prio [DEPTH];
  logic [DEP_W-1:0]   depth;

  wire [2:0] region = bus_addr[7:5];
  wire [4:0] idx    = bus_addr[4:0];

  logic [NUM_IRQ-1:0] set_en, clr_en, set_pd, clr_pd;
  always_comb begin
    set_en = '0; clr_en = '0; set_pd = '0; clr_pd = '0;
    bus_rdata = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (idx == 5'(w)) begin
        if (bus_wr) begin
          if (region == 3'd0) set_en[w*32 +: 32] = bus_wdata;
          if (region == 3'd1) clr_en[w*32 +: 32] = bus_wdata;
          if (region == 3'd2) set_pd[w*32 +: 32] = bus_wdata;
          if (region == 3'd3) clr_pd[w*32 +: 32] = bus_wdata;
        end
        if (region == 3'd0 || region == 3'd1) bus_rdata = en[w*32 +: 32];
        if (region == 3'd2 || region == 3'd3) bus_rdata = pend[w*32 +: 32];
        if (region == 3'd4) bus_rdata = act[w*32 +: 32];
      end
    end
    for (int p = 0; p < PWORDS; p++)
      if (region == 3'd5 && idx == 5'(p))
        for (int k = 0; k < PER_PW; k++)
          bus_rdata[k*PRIO_W +: PRIO_W] = prio[p*PER_PW + k];
  end

  logic              win_found;
  logic [LINE_W-1:0] win_line;
  logic [PRIO_W-1:0] win_prio;
  always_comb begin
    win_found = 1'b0; win_line = '0; win_prio = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (pend[i] && en[i] && (!win_found || prio[i] < win_prio)) begin
        win_found = 1'b1; win_line = LINE_W'(i); win_prio = prio[i];
      end
  end

  logic [LINE_W-1:0] top_line;
  logic [PRIO_W-1:0] top_prio;
  always_comb begin
    top_line = '0; top_prio = '0;
    for (int d = 0; d < DEPTH; d++)
      if (depth == DEP_W'(d + 1)) begin
        top_line = stk_line[d]; top_prio = stk_prio[d];
      end
  end

  assign irq_valid = win_found && depth != FULL && (depth == '0 || win_prio < top_prio);
  assign irq_num   = EXC_W'(win_line) + EXC_W'(EXC_OFS);

  wire take  = core_ack && irq_valid && !core_exit;
  wire leave = core_exit && depth != '0;
  wire [NUM_IRQ-1:0] ack_bit  = take  ? (ONE << win_line) : '0;
  wire [NUM_IRQ-1:0] exit_bit = leave ? (ONE << top_line) : '0;
  wire [NUM_IRQ-1:0] rise     = irq_lines & ~prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= '0; pend <= '0; act <= '0; prev <= '0; depth <= '0;
      for (int i = 0; i < NUM_IRQ; i++) prio[i] <= '0;
      for (int d = 0; d < DEPTH; d++) begin
        stk_line[d] <= '0; stk_prio[d] <= '0;
      end
    end else begin
      prev <= irq_lines;
      en   <= (en | set_en) & ~clr_en;
      pend <= (pend & ~clr_pd & ~ack_bit) | set_pd | rise;
      act  <= (act | ack_bit) & ~exit_bit;
      if (bus_wr && region == 3'd5)
        for (int p = 0; p < PWORDS; p++)
          if (idx == 5'(p))
            for (int k = 0; k < PER_PW; k++)
              prio[p*PER_PW + k] <= bus_wdata[k*PRIO_W +: PRIO_W];
      if (leave) depth <= depth - DEP_W'(1);
      else if (take) begin
        for (int d = 0; d < DEPTH; d++)
          if (depth == DEP_W'(d)) begin
            stk_line[d] <= win_line; stk_prio[d] <= win_prio;
          end
        depth <= depth + DEP_W'(1);
      end
    end
  end

  a_r7_ack_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> act[$past(win_line)]);
  a_r8_exit_pops: assert property (@(posedge clk) disable iff (!rst_n)
    leave |=> depth == $past(depth) - DEP_W'(1));
  a_r8_active_within_depth: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act) <= int'(depth));
  a_r9_edge_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend & $past(rise)) == $past(rise)));
  a_r10_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    depth == FULL |-> !irq_valid);
  a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= FULL);
endmodule

// File: tb/nested_irq_ctrl_test.sv
`timescale 1ns/100ps
module nested_irq_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, core_ack = 1'b0, core_exit = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [63:0] irq_lines = '0;
  logic irq_valid;
  logic [8:0] irq_num;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [3:0] sh [64];

  nested_irq_ctrl uut (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .irq_lines, .core_ack, .core_exit, .irq_valid, .irq_num);

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic [31:0] pword(input int p);
    logic [31:0] w;
    for (int k = 0; k < 8; k++) w[k*4 +: 4] = sh[p*8 + k];
    return w;
  endfunction

  task automatic set_prio(input int n, input logic [3:0] v);
    sh[n] = v; wr(8'hA0 + 8'(n/8), pword(n/8));
  endtask

  task automatic arm(input int n);
    wr(8'h40 + 8'(n/32), 32'h1 << (n%32));
    wr(8'h00 + 8'(n/32), 32'h1 << (n%32));
  endtask

  task automatic pulse_ack;
    @(negedge clk); core_ack = 1'b1; @(negedge clk); core_ack = 1'b0;
  endtask

  task automatic pulse_exit;
    @(negedge clk); core_exit = 1'b1; @(negedge clk); core_exit = 1'b0;
  endtask

  task automatic wipe;
    wr(8'h20, '1); wr(8'h21, '1); wr(8'h60, '1); wr(8'h61, '1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit gone [64];
    for (int i = 0; i < 64; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 2; a++) begin
      rd(8'h00 + 8'(a), d); check("R12 enable reset", d, 0);
      rd(8'h40 + 8'(a), d); check("R12 pending reset", d, 0);
      rd(8'h80 + 8'(a), d); check("R12 active reset", d, 0);
    end
    rd(8'hA3, d); check("R12 priority reset", d, 0);
    check("R12 irq_valid reset", 32'(irq_valid), 0);

    wr(8'h00, 32'hA5A5_0000); wr(8'h00, 32'h0000_000F);
    rd(8'h00, d); check("R1 set-enable union", d, 32'hA5A5_000F);
    wr(8'h00, 32'h0); rd(8'h20, d); check("R1 zero write no effect", d, 32'hA5A5_000F);
    wr(8'h01, 32'h8000_0001); rd(8'h01, d); check("R1 word 1", d, 32'h8000_0001);
    wr(8'h20, 32'h0000_0005); rd(8'h00, d); check("R2 clear-enable", d, 32'hA5A5_000A);
    wr(8'h20, 32'h0); rd(8'h00, d); check("R2 zero write no effect", d, 32'hA5A5_000A);
    wipe;
    wr(8'h41, 32'h1234_5678); rd(8'h41, d); check("R3 set-pending read", d, 32'h1234_5678);
    wr(8'h61, 32'h0000_00F0); rd(8'h61, d); check("R3 clear-pending read", d, 32'h1234_5608);
    wr(8'h41, 32'h0); wr(8'h61, 32'h0); rd(8'h41, d); check("R3 zero writes", d, 32'h1234_5608);
    wipe;

    for (int i = 0; i < 64; i++) sh[i] = 4'((i*7 + 3) % 16);
    for (int p = 0; p < 8; p++) wr(8'hA0 + 8'(p), pword(p));
    for (int p = 0; p < 8; p++) begin
      rd(8'hA0 + 8'(p), d); check("R11 priority readback", d, pword(p));
    end
    wr(8'h40, '1); wr(8'h41, '1); wr(8'h00, '1); wr(8'h01, '1);
    for (int i = 0; i < 64; i++) gone[i] = 0;
    for (int s = 0; s < 64; s++) begin
      int best;
      best = -1;
      for (int i = 0; i < 64; i++)
        if (!gone[i] && (best < 0 || sh[i] < sh[best])) best = i;
      @(negedge clk);
      check("R5 sweep valid", 32'(irq_valid), 1);
      check("R5 sweep number", 32'(irq_num), 32'(best + 16));
      gone[best] = 1;
      wr(8'h20 + 8'(best/32), 32'h1 << (best%32));
    end
    check("R5 none enabled", 32'(irq_valid), 0);
    wipe;

    set_prio(40, 4'd10);
    @(negedge clk); irq_lines[40] = 1'b1; @(negedge clk);
    rd(8'h41, d); check("R4 disabled edge pends", d, 32'h100);
    check("R4 disabled not offered", 32'(irq_valid), 0);
    wr(8'h01, 32'h100); @(negedge clk);
    check("R4 offered once enabled", 32'(irq_valid), 1);
    check("R4 number", 32'(irq_num), 56);
    pulse_ack;
    rd(8'h41, d); check("R7 pending cleared", d, 0);
    rd(8'h81, d); check("R7 active set", d, 32'h100);
    rd(8'h01, d); check("R7 enable kept", d, 32'h100);

    set_prio(3, 4'd10); arm(3); @(negedge clk);
    check("R6 equal priority blocked", 32'(irq_valid), 0);
    set_prio(3, 4'd8); @(negedge clk);
    check("R6 higher preempts", 32'(irq_valid), 1);
    check("R6 number", 32'(irq_num), 19);
    pulse_ack;
    set_prio(5, 4'd6); arm(5); pulse_ack;
    set_prio(6, 4'd4); arm(6); pulse_ack;
    rd(8'h80, d); check("R7 nested active", d, 32'h68);
    set_prio(7, 4'd2); arm(7); @(negedge clk);
    check("R10 full stack blocks", 32'(irq_valid), 0);
    pulse_exit;
    check("R10 offered after exit", 32'(irq_valid), 1);
    check("R10 number", 32'(irq_num), 23);
    rd(8'h80, d); check("R8 innermost cleared", d, 32'h28);
    pulse_exit; pulse_exit;
    rd(8'h80, d); check("R8 two more exits", d, 0);
    rd(8'h81, d); check("R8 outer still active", d, 32'h100);
    pulse_exit;
    rd(8'h81, d); check("R8 all exited", d, 0);
    check("R6 none active offers", 32'(irq_valid), 1);
    @(negedge clk); core_ack = 1'b1; core_exit = 1'b1;
    @(negedge clk); core_ack = 1'b0; core_exit = 1'b0;
    rd(8'h80, d); check("R8 exit beats ack", d, 0);

    wr(8'h60, 32'h80); rd(8'h40, d); check("R3 clear-pending line 7", d, 0);
    @(negedge clk); irq_lines[9] = 1'b1;
    bus_addr = 8'h60; bus_wdata = 32'h200; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(8'h40, d); check("R9 edge beats clear", d, 32'h200);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule